// File: doc/BRIEF.md
# VGA Read Path with Colour Compare

This block sits on the CPU read side of a planar VGA frame buffer. When the memory returns a longword for a CPU read, the block keeps the whole longword in a display latch and, on the same clock edge, produces the byte returned to the CPU. The write path uses the latch as a data source. Software can also load the latch directly and read it back as a 32-bit register.

The longword holds one byte per plane. Plane p occupies bits [8p+7:8p], so plane 0 is the low byte. The returned byte comes from one of two read modes. In plane mode, the byte is the contents of one plane. That plane is named by the read-map select when chaining is off, and by the chain plane select when chaining is on. In colour-compare mode, each of the eight pixel positions reports whether its planes match a 4-bit compare colour. A per-plane mask limits the comparison to some of the planes. Addressing and memory timing are handled outside this block.

Top module: `vga_rdpath`

## Requirements
- R1: While rst_n is low, latch_q and cpu_byte are both 0.
- R2: A clock edge with rd_stb high loads rd_data into latch_q and the selected result into cpu_byte at that same edge.
- R3: A clock edge with sw_wr_en high and rd_stb low loads sw_wr_data into latch_q and leaves cpu_byte unchanged.
- R4: When rd_stb and sw_wr_en are both high, the memory read wins and latch_q takes rd_data.
- R5: With rd_mode=0 and chain_rd=0, cpu_byte is plane map_sel of rd_data, where plane p is bits [8p+7:8p].
- R6: With rd_mode=0 and chain_rd=1, cpu_byte is plane chain_plane of rd_data and map_sel has no effect.
- R7: With rd_mode=1, bit i of cpu_byte is 1 exactly when, for every plane p with cmp_mask[p]=1, bit i of plane p equals cmp_color[p].
- R8: With rd_mode=1 and cmp_mask=0, cpu_byte is 8'hFF whatever the data.
- R9: A clock edge with rd_stb and sw_wr_en both low changes neither latch_q nor cpu_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Memory read data valid this cycle |
| rd_data | input | 32 | Longword returned by memory, one byte per plane |
| sw_wr_en | input | 1 | Software load of the display latch |
| sw_wr_data | input | 32 | Value software writes into the latch |
| rd_mode | input | 1 | 0 = plane read, 1 = colour compare |
| map_sel | input | 2 | Plane to read when unchained |
| chain_rd | input | 1 | Chained read active (chain 2 or chain 4) |
| chain_plane | input | 2 | Plane chosen by chained addressing |
| cmp_color | input | 4 | Compare colour, one bit per plane |
| cmp_mask | input | 4 | Planes that take part in the compare |
| cpu_byte | output | 8 | Byte returned to the CPU |
| latch_q | output | 32 | Display latch contents |

## Verification
If the latch register held a wrong value, latch_q would show it one edge after the load and would keep showing it until the next load. Software can then see the error directly, and so can the write path. A fault in the plane mux or in the compare network shows up in cpu_byte at the same edge as the read. It shows only for some mask, colour and select combinations, so the vectors vary each of these fields on its own and use plane bytes that differ from one another. A fault in the load priority between the two latch sources shows in latch_q only on the cycle when both sources are active.

// File: rtl/vga_rd_pkg.sv
package vga_rd_pkg;
  localparam int unsigned VGA_PLANES  = 4;
  localparam int unsigned VGA_PLANE_W = 8;

  typedef enum logic {
    RD_PLANE = 1'b0,
    RD_CMP   = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/vga_rd_latch.sv
module vga_rd_latch #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mem,
  input  logic [WORD_W-1:0] mem_data,
  input  logic              ld_sw,
  input  logic [WORD_W-1:0] sw_data,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] q_d;
  logic              q_en;

  // memory read has priority over the software load
  always_comb begin
    q_en = ld_mem | ld_sw;
    q_d  = ld_mem ? mem_data : sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/vga_rd_plane_sel.sv
module vga_rd_plane_sel #(
  parameter int unsigned NUM_PLANES = 4,
  parameter int unsigned PLANE_W    = 8,
  localparam int unsigned WORD_W    = NUM_PLANES * PLANE_W,
  localparam int unsigned SEL_W     = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [SEL_W-1:0]   idx,
  output logic [PLANE_W-1:0] plane
);
  logic [PLANE_W-1:0] planes [NUM_PLANES];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_split
    assign planes[p] = word[p*PLANE_W +: PLANE_W];
  end

  always_comb begin
    plane = '0;
    for (int p = 0; p < NUM_PLANES; p++) begin
      if (idx == SEL_W'(p)) plane = planes[p];
    end
  end
endmodule

// File: rtl/vga_rd_ccmp.sv
module vga_rd_ccmp #(
  parameter int unsigned NUM_PLANES = 4,
  parameter int unsigned PLANE_W    = 8,
  localparam int unsigned WORD_W    = NUM_PLANES * PLANE_W
) (
  input  logic [WORD_W-1:0]     word,
  input  logic [NUM_PLANES-1:0] color,
  input  logic [NUM_PLANES-1:0] mask,
  output logic [PLANE_W-1:0]    match
);
  for (genvar i = 0; i < PLANE_W; i++) begin : g_pix
    logic [NUM_PLANES-1:0] ok;
    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_pl
      // a plane left out by the mask always agrees
      assign ok[p] = ~mask[p] | ~(word[p*PLANE_W + i] ^ color[p]);
    end
    assign match[i] = &ok;
  end
endmodule

// File: rtl/vga_rdpath.sv
module vga_rdpath
  import vga_rd_pkg::*;
#(
  parameter int unsigned NUM_PLANES = VGA_PLANES,
  parameter int unsigned PLANE_W    = VGA_PLANE_W,
  localparam int unsigned WORD_W    = NUM_PLANES * PLANE_W,
  localparam int unsigned SEL_W     = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_stb,
  input  logic [WORD_W-1:0]     rd_data,
  input  logic                  sw_wr_en,
  input  logic [WORD_W-1:0]     sw_wr_data,
  input  logic                  rd_mode,
  input  logic [SEL_W-1:0]      map_sel,
  input  logic                  chain_rd,
  input  logic [SEL_W-1:0]      chain_plane,
  input  logic [NUM_PLANES-1:0] cmp_color,
  input  logic [NUM_PLANES-1:0] cmp_mask,
  output logic [PLANE_W-1:0]    cpu_byte,
  output logic [WORD_W-1:0]     latch_q
);
  rd_mode_e           mode;
  logic [SEL_W-1:0]   plane_idx;
  logic [PLANE_W-1:0] plane_byte;
  logic [PLANE_W-1:0] cmp_byte;
  logic [PLANE_W-1:0] byte_d;
  logic               byte_en;

  vga_rd_latch #(.WORD_W(WORD_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_mem   (rd_stb),
    .mem_data (rd_data),
    .ld_sw    (sw_wr_en),
    .sw_data  (sw_wr_data),
    .q        (latch_q)
  );

  vga_rd_plane_sel #(.NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W)) u_psel (
    .word  (rd_data),
    .idx   (plane_idx),
    .plane (plane_byte)
  );

  vga_rd_ccmp #(.NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W)) u_ccmp (
    .word  (rd_data),
    .color (cmp_color),
    .mask  (cmp_mask),
    .match (cmp_byte)
  );

  always_comb begin
    mode      = rd_mode_e'(rd_mode);
    plane_idx = chain_rd ? chain_plane : map_sel;
    byte_en   = rd_stb;
    byte_d    = (mode == RD_CMP) ? cmp_byte : plane_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpu_byte <= '0;
    else if (byte_en) cpu_byte <= byte_d;
  end
endmodule

// File: rtl/vga_rdpath_chk.sv
module vga_rdpath_chk #(
  parameter int unsigned NUM_PLANES = 4,
  parameter int unsigned PLANE_W    = 8,
  localparam int unsigned WORD_W    = NUM_PLANES * PLANE_W,
  localparam int unsigned SEL_W     = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_stb,
  input logic [WORD_W-1:0]     rd_data,
  input logic                  sw_wr_en,
  input logic [WORD_W-1:0]     sw_wr_data,
  input logic                  rd_mode,
  input logic [SEL_W-1:0]      map_sel,
  input logic                  chain_rd,
  input logic [SEL_W-1:0]      chain_plane,
  input logic [NUM_PLANES-1:0] cmp_mask,
  input logic [PLANE_W-1:0]    cpu_byte,
  input logic [WORD_W-1:0]     latch_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (latch_q == '0 && cpu_byte == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  a_r2_r4_mem_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> latch_q == $past(rd_data));

  a_r3_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !rd_stb) |=> (latch_q == $past(sw_wr_data)) && $stable(cpu_byte));

  a_r5_plane_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_mode && !chain_rd) |=> cpu_byte == $past(rd_data[map_sel*PLANE_W +: PLANE_W]));

  a_r6_chain_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_mode && chain_rd) |=> cpu_byte == $past(rd_data[chain_plane*PLANE_W +: PLANE_W]));

  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_mode && cmp_mask == '0) |=> cpu_byte == '1);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !sw_wr_en) |=> $stable(latch_q) && $stable(cpu_byte));
endmodule

bind vga_rdpath vga_rdpath_chk #(.NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_stb      (rd_stb),
  .rd_data     (rd_data),
  .sw_wr_en    (sw_wr_en),
  .sw_wr_data  (sw_wr_data),
  .rd_mode     (rd_mode),
  .map_sel     (map_sel),
  .chain_rd    (chain_rd),
  .chain_plane (chain_plane),
  .cmp_mask    (cmp_mask),
  .cpu_byte    (cpu_byte),
  .latch_q     (latch_q)
);

// File: tb/sim_vga_rdpath.sv
`timescale 1ns/1ps
module sim_vga_rdpath;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        mode;
    logic        chain;
    logic [1:0]  msel;
    logic [1:0]  cpl;
    logic [3:0]  col;
    logic [3:0]  msk;
    logic [31:0] data;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  // planes of A5C30FF0: p0=F0 p1=0F p2=C3 p3=A5 ; 12345678: p0=78 p1=56 p2=34 p3=12
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd0, 2'd2, 4'h0, 4'h0, 32'hA5C30FF0, 8'hF0, 4'd5}, // R5
    '{1'b0, 1'b0, 2'd2, 2'd0, 4'h0, 4'h0, 32'hA5C30FF0, 8'hC3, 4'd5}, // R5
    '{1'b0, 1'b0, 2'd3, 2'd1, 4'h0, 4'h0, 32'hA5C30FF0, 8'hA5, 4'd5}, // R5
    '{1'b0, 1'b1, 2'd3, 2'd1, 4'h0, 4'h0, 32'hA5C30FF0, 8'h0F, 4'd6}, // R6
    '{1'b0, 1'b1, 2'd0, 2'd2, 4'h0, 4'h0, 32'h12345678, 8'h34, 4'd6}, // R6
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'h5, 4'h0, 32'hA5C30FF0, 8'hFF, 4'd8}, // R8
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'h1, 4'h1, 32'hA5C30FF0, 8'hF0, 4'd7}, // R7
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'h1, 4'h3, 32'hA5C30FF0, 8'hF0, 4'd7}, // R7
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'h0, 4'hF, 32'hA5C30FF0, 8'h00, 4'd7}, // R7
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'hC, 4'hC, 32'hA5C30FF0, 8'h81, 4'd7}, // R7
    '{1'b1, 1'b1, 2'd1, 2'd3, 4'h0, 4'h4, 32'hA5C30FF0, 8'h3C, 4'd7}, // R7
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'h2, 4'h2, 32'h12345678, 8'h56, 4'd7}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_stb, sw_wr_en, rd_mode, chain_rd;
  logic [31:0] rd_data, sw_wr_data;
  logic [1:0]  map_sel, chain_plane;
  logic [3:0]  cmp_color, cmp_mask;
  logic [7:0]  cpu_byte;
  logic [31:0] latch_q;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_rdpath u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .rd_mode(rd_mode),
    .map_sel(map_sel), .chain_rd(chain_rd), .chain_plane(chain_plane),
    .cmp_color(cmp_color), .cmp_mask(cmp_mask),
    .cpu_byte(cpu_byte), .latch_q(latch_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_stb = 0; sw_wr_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    rd_data = 32'h0; sw_wr_data = 32'h0; rd_mode = 0; map_sel = 0;
    chain_rd = 0; chain_plane = 0; cmp_color = 0; cmp_mask = 0;
    repeat (2) @(negedge clk);
    chk("R1 latch in reset", latch_q, 32'h0);
    chk("R1 byte in reset", {24'h0, cpu_byte}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      rd_stb = 1; rd_data = VEC[k].data; rd_mode = VEC[k].mode;
      chain_rd = VEC[k].chain; map_sel = VEC[k].msel; chain_plane = VEC[k].cpl;
      cmp_color = VEC[k].col; cmp_mask = VEC[k].msk;
      @(negedge clk);
      idle();
      checks++;
      if (cpu_byte !== VEC[k].exp) begin
        errors++;
        $display("FAIL R%0d vec %0d actual=%h expected=%h", VEC[k].req, k, cpu_byte, VEC[k].exp);
      end
      chk("R2 latch load on read", latch_q, VEC[k].data);
    end

    // R9: inputs change but no strobe
    rd_data = 32'hDEADBEEF; rd_mode = 0; chain_rd = 0; map_sel = 1;
    @(negedge clk);
    chk("R9 latch hold", latch_q, 32'h12345678);
    chk("R9 byte hold", {24'h0, cpu_byte}, 32'h56);

    // R3: software load
    sw_wr_en = 1; sw_wr_data = 32'hCAFE0123;
    @(negedge clk);
    idle();
    chk("R3 sw latch load", latch_q, 32'hCAFE0123);
    chk("R3 byte unchanged", {24'h0, cpu_byte}, 32'h56);

    // R4: both sources in one cycle
    rd_stb = 1; sw_wr_en = 1; rd_data = 32'h0BADF00D; sw_wr_data = 32'h11111111;
    map_sel = 3;
    @(negedge clk);
    idle();
    chk("R4 read wins", latch_q, 32'h0BADF00D);
    chk("R5 byte with both", {24'h0, cpu_byte}, 32'h0B);

    // R6: map_sel changes but chained plane fixed
    rd_stb = 1; chain_rd = 1; chain_plane = 0; map_sel = 2; rd_data = 32'h44332211;
    @(negedge clk);
    idle();
    chk("R6 map_sel ignored", {24'h0, cpu_byte}, 32'h11);

    // R8: empty mask with other data
    rd_stb = 1; rd_mode = 1; cmp_mask = 0; cmp_color = 4'hF; rd_data = 32'h00000000;
    @(negedge clk);
    idle();
    chk("R8 empty mask", {24'h0, cpu_byte}, 32'hFF);

    // R1: asynchronous reset mid-run
    #(CLK_PERIOD/4) rst_n = 0;
    #1;
    chk("R1 latch async clear", latch_q, 32'h0);
    chk("R1 byte async clear", {24'h0, cpu_byte}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule